// File: doc/BRIEF.md
# Cascadable Eight-Function Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit built from identical 4-bit slices. A 3-bit function code picks one of eight operations: force the result to zero, two subtractions (one of each operand order), addition with carry-in, three bitwise logic operations, and force the result to all ones. Each slice exposes a carry-in, a carry-out and a two's-complement overflow flag.

The top module joins a parameterized number of slices into one wider unit, two by default, which gives an 8-bit unit. Each slice's carry-out feeds the carry-in of the next slice up. The carry-out and overflow of the whole unit come from the most significant slice. Subtraction inverts the subtrahend and adds it together with the carry-in. A caller therefore sets the carry-in to 1 for a true difference, or to 0 to subtract one more, which acts as a borrow-in.

Top module: `cascade_alu`

## Requirements
- R1: With function code 000 the result is all zeros, and carry-out and overflow are 0, whatever the operands and carry-in are.
- R2: With function code 001 the result is B + ~A + cin modulo 2^N (B minus A when cin is 1). Carry-out is the carry out of that sum's most significant bit, where 1 means no borrow.
- R3: With function code 010 the result is A + ~B + cin modulo 2^N (A minus B when cin is 1). Carry-out is the carry out of the most significant bit.
- R4: With function code 011 the result is A + B + cin modulo 2^N, and carry-out is the carry out of the most significant bit.
- R5: With function codes 100, 101 and 110 the result is A XOR B, A OR B and A AND B, bit by bit, and carry-out and overflow are 0.
- R6: With function code 111 the result is all ones, and carry-out and overflow are 0.
- R7: For codes 001, 010 and 011 the overflow is 1 exactly when the two added values (after any inversion) have the same sign bit and the result's sign bit differs from it.
- R8: Carries ripple from slice to slice, so results across the full N-bit width match N-bit arithmetic. Carry-out and overflow come from the most significant slice.
- R9: For codes 000 and 100 through 111 the carry-in has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| fsel | input | 3 | Function code |
| cin | input | 1 | Carry-in to the lowest slice |
| res | output | 8 | Result |
| cout | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Two's-complement overflow |

## Verification
Two functions can act in the same evaluation: the carry that crosses a slice boundary, and the overflow decision made in the top slice. Operand pairs such as 7F+01, 80+80 and 80−01 make the top slice's carry-in differ from its own carry-out. In these cases the overflow must be set while the carry-out is either 0 or 1, and a result judged only by its low nibble would be wrong. Each such vector is compared against hand-worked result, carry and overflow values, and then against a bench model over a sweep of operands and every function code.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        FN_CLR   = 3'b000,
        FN_BSUBA = 3'b001,
        FN_ASUBB = 3'b010,
        FN_ADD   = 3'b011,
        FN_XOR   = 3'b100,
        FN_OR    = 3'b101,
        FN_AND   = 3'b110,
        FN_SET   = 3'b111
    } alu_fn_e;

    function automatic logic fn_is_arith(input alu_fn_e fn);
        return (fn == FN_BSUBA) || (fn == FN_ASUBB) || (fn == FN_ADD);
    endfunction

endpackage

// File: rtl/nib_adder.sv
module nib_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         ci_i,
    output logic [W-1:0] s_o,
    output logic         co_o,
    output logic         cmsb_o
);

    always_comb begin
        logic c;
        c      = ci_i;
        cmsb_o = 1'b0;
        s_o    = '0;
        for (int i = 0; i < W; i++) begin
            if (i == W - 1) cmsb_o = c;
            s_o[i] = x_i[i] ^ y_i[i] ^ c;
            c      = (x_i[i] & y_i[i]) | ((x_i[i] ^ y_i[i]) & c);
        end
        co_o = c;
    end

endmodule

// File: rtl/slice_logic.sv
module slice_logic import alu_pkg::*; #(
    parameter int W = 4
) (
    input  alu_fn_e      fn_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] f_o
);

    always_comb begin
        unique case (fn_i)
            FN_XOR:  f_o = a_i ^ b_i;
            FN_OR:   f_o = a_i | b_i;
            FN_AND:  f_o = a_i & b_i;
            default: f_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice import alu_pkg::*; #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_fn_e      fn_i,
    input  logic         ci_i,
    output logic [W-1:0] f_o,
    output logic         co_o,
    output logic         ov_o
);

    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
    } opnd_t;

    typedef struct packed {
        logic [W-1:0] f;
        logic         co;
        logic         ov;
    } slice_out_t;

    opnd_t        opnd_d;
    slice_out_t   out_d;
    logic [W-1:0] sum;
    logic         add_co;
    logic         c_msb;
    logic [W-1:0] log_f;

    // operand conditioning: the subtrahend is inverted, carry-in supplies the +1
    always_comb begin
        unique case (fn_i)
            FN_BSUBA: opnd_d = '{x: b_i, y: ~a_i};
            FN_ASUBB: opnd_d = '{x: a_i, y: ~b_i};
            default:  opnd_d = '{x: a_i, y: b_i};
        endcase
    end

    nib_adder #(.W(W)) u_add (
        .x_i    (opnd_d.x),
        .y_i    (opnd_d.y),
        .ci_i   (ci_i),
        .s_o    (sum),
        .co_o   (add_co),
        .cmsb_o (c_msb)
    );

    slice_logic #(.W(W)) u_log (
        .fn_i (fn_i),
        .a_i  (a_i),
        .b_i  (b_i),
        .f_o  (log_f)
    );

    always_comb begin
        out_d = '0;
        if (fn_is_arith(fn_i)) begin
            out_d.f  = sum;
            out_d.co = add_co;
            out_d.ov = add_co ^ c_msb;
        end else if (fn_i == FN_CLR) begin
            out_d.f = '0;
        end else if (fn_i == FN_SET) begin
            out_d.f = '1;
        end else begin
            out_d.f = log_f;
        end

        // R1: clear gives zero result and quiet flags
        if (fn_i == FN_CLR)
            a_r1_clear: assert (out_d.f == '0 && !out_d.co && !out_d.ov)
                else $error("R1 clear output wrong");
        // R6: preset gives all ones and quiet flags
        if (fn_i == FN_SET)
            a_r6_preset: assert (out_d.f == '1 && !out_d.co && !out_d.ov)
                else $error("R6 preset output wrong");
        // R4: add result against plain arithmetic
        if (fn_i == FN_ADD)
            a_r4_add_sum: assert ({out_d.co, out_d.f} ==
                                  ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(ci_i)))
                else $error("R4 slice sum wrong");
        // R7: overflow from sign bits of an addition
        if (fn_i == FN_ADD)
            a_r7_add_overflow: assert (out_d.ov ==
                ((a_i[W-1] == b_i[W-1]) && (out_d.f[W-1] != a_i[W-1])))
                else $error("R7 slice overflow wrong");
        // R5: logic codes keep flags at 0
        if (!fn_is_arith(fn_i))
            a_r5_quiet_flags: assert (!out_d.co && !out_d.ov)
                else $error("R5 flags not quiet");
    end

    assign f_o  = out_d.f;
    assign co_o = out_d.co;
    assign ov_o = out_d.ov;

endmodule

// File: rtl/cascade_alu.sv
module cascade_alu import alu_pkg::*; #(
    parameter int SLICE_W = 4,
    parameter int SLICES  = 2,
    localparam int TOT_W  = SLICE_W * SLICES
) (
    input  logic [TOT_W-1:0] opa,
    input  logic [TOT_W-1:0] opb,
    input  logic [2:0]       fsel,
    input  logic             cin,
    output logic [TOT_W-1:0] res,
    output logic             cout,
    output logic             ovf
);

    alu_fn_e           fn;
    logic [SLICES:0]   cy;
    logic [SLICES-1:0] sl_ov;

    assign fn    = alu_fn_e'(fsel);
    assign cy[0] = cin;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        alu_slice #(.W(SLICE_W)) u_slice (
            .a_i  (opa[k*SLICE_W +: SLICE_W]),
            .b_i  (opb[k*SLICE_W +: SLICE_W]),
            .fn_i (fn),
            .ci_i (cy[k]),
            .f_o  (res[k*SLICE_W +: SLICE_W]),
            .co_o (cy[k+1]),
            .ov_o (sl_ov[k])
        );
    end

    assign cout = cy[SLICES];
    assign ovf  = sl_ov[SLICES-1];

    always_comb begin
        // R8: full-width addition across the slice chain
        if (fn == FN_ADD)
            a_r8_wide_add: assert ({cout, res} ==
                ({1'b0, opa} + {1'b0, opb} + (TOT_W+1)'(cin)))
                else $error("R8 wide add wrong");
        // R3: full-width A minus B through inverted operand
        if (fn == FN_ASUBB)
            a_r3_wide_sub: assert ({cout, res} ==
                ({1'b0, opa} + {1'b0, ~opb} + (TOT_W+1)'(cin)))
                else $error("R3 wide subtract wrong");
        // R2: full-width B minus A
        if (fn == FN_BSUBA)
            a_r2_wide_rsub: assert ({cout, res} ==
                ({1'b0, opb} + {1'b0, ~opa} + (TOT_W+1)'(cin)))
                else $error("R2 wide reverse subtract wrong");
        // R5: no slice raises overflow for non-arithmetic codes
        if (!fn_is_arith(fn))
            a_r5_no_overflow: assert (sl_ov == '0 && !cout)
                else $error("R5 slice flags set");
    end

endmodule

// File: tb/cascade_alu_test.sv
module cascade_alu_test;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;
    localparam int NVEC       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa, opb;
    logic [2:0] fsel;
    logic       cin;
    logic [7:0] res;
    logic       cout, ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    cascade_alu uut (
        .opa  (opa),
        .opb  (opb),
        .fsel (fsel),
        .cin  (cin),
        .res  (res),
        .cout (cout),
        .ovf  (ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // fsel | a | b | cin || res | cout | ovf
    localparam logic [29:0] VEC [NVEC] = '{
        {3'd0, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0, 1'b0},
        {3'd1, 8'h04, 8'h06, 1'b1, 8'h02, 1'b1, 1'b0},
        {3'd1, 8'h06, 8'h04, 1'b1, 8'hFE, 1'b0, 1'b0},
        {3'd2, 8'h04, 8'h06, 1'b1, 8'hFE, 1'b0, 1'b0},
        {3'd2, 8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 1'b1},
        {3'd3, 8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b1},
        {3'd3, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0},
        {3'd3, 8'h0F, 8'h00, 1'b1, 8'h10, 1'b0, 1'b0},
        {3'd4, 8'hF0, 8'h3C, 1'b0, 8'hCC, 1'b0, 1'b0},
        {3'd5, 8'hF0, 8'h0F, 1'b1, 8'hFF, 1'b0, 1'b0},
        {3'd6, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b0, 1'b0},
        {3'd7, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0},
        {3'd2, 8'h05, 8'h03, 1'b0, 8'h01, 1'b1, 1'b0},
        {3'd1, 8'h80, 8'h7F, 1'b1, 8'hFF, 1'b0, 1'b1},
        {3'd3, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1},
        {3'd3, 8'h08, 8'h08, 1'b0, 8'h10, 1'b0, 1'b0}
    };

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd2:    return "R3";
            3'd3:    return "R4";
            3'd7:    return "R6";
            default: return "R5";
        endcase
    endfunction

    // model built from the requirements
    function automatic logic [9:0] model(input logic [2:0] f, input logic [7:0] a,
                                         input logic [7:0] b, input logic c);
        logic [7:0] x, y;
        logic [8:0] s;
        logic       ov;
        case (f)
            3'd0: return {8'h00, 2'b00};
            3'd4: return {a ^ b, 2'b00};
            3'd5: return {a | b, 2'b00};
            3'd6: return {a & b, 2'b00};
            3'd7: return {8'hFF, 2'b00};
            default: begin
                x = (f == 3'd1) ? b : a;
                y = (f == 3'd1) ? ~a : (f == 3'd2) ? ~b : b;
                s = {1'b0, x} + {1'b0, y} + {8'd0, c};
                ov = (x[7] == y[7]) && (s[7] != x[7]);
                return {s[7:0], s[8], ov};
            end
        endcase
    endfunction

    task automatic apply(input logic [2:0] f, input logic [7:0] a,
                         input logic [7:0] b, input logic c);
        @(posedge clk);
        fsel = f; opa = a; opb = b; cin = c;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] er,
                       input logic ec, input logic eo);
        checks++;
        if (res !== er || cout !== ec || ovf !== eo) begin
            errors++;
            $display("FAIL %s: fsel=%0d a=%h b=%h cin=%0b got res=%h cout=%0b ovf=%0b exp res=%h cout=%0b ovf=%0b",
                     req, fsel, opa, opb, cin, res, cout, ovf, er, ec, eo);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_LIMIT && !done) begin
                errors++;
                $display("FAIL watchdog: expired after %0d cycles, exp completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] r0;
        fsel = 3'd0; opa = 8'h00; opb = 8'h00; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 8'h00, 1'b0, 1'b0);

        // table of hand-worked vectors (R7 overflow and R8 slice carry among them)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][29:27], VEC[i][26:19], VEC[i][18:11], VEC[i][10]);
            chk(req_of(VEC[i][29:27]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R8 carry across boundary with overflow in top slice
        apply(3'd3, 8'h7F, 8'h01, 1'b0);
        chk("R8 R7 boundary carry", 8'h80, 1'b0, 1'b1);

        // R9: carry-in ignored by clear, logic and preset codes
        for (int f = 0; f < 8; f++) begin
            if (f >= 1 && f <= 3) continue;
            apply(3'(f), 8'hA5, 8'h5A, 1'b0);
            r0 = res;
            apply(3'(f), 8'hA5, 8'h5A, 1'b1);
            checks++;
            if (res !== r0 || cout !== 1'b0 || ovf !== 1'b0) begin
                errors++;
                $display("FAIL R9: fsel=%0d got res=%h cout=%0b ovf=%0b exp res=%h cout=0 ovf=0",
                         f, res, cout, ovf, r0);
            end
        end

        // sweep all codes against model
        for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 256; a += 37) begin
                for (int b = 0; b < 256; b += 51) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [9:0] m;
                        apply(3'(f), 8'(a), 8'(b), 1'(c));
                        m = model(3'(f), 8'(a), 8'(b), 1'(c));
                        chk((f >= 1 && f <= 3) ? "R8 R7 sweep" : req_of(3'(f)),
                            m[9:2], m[1], m[0]);
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule